// File: doc/BRIEF.md
# Multi-Controlled Toggle Register Array

This block holds a row of single-bit cells that change state only through a shared condition line. An external instruction sequencer presents two masks each cycle: a test mask that picks the cells whose state gates the operation, and a flip mask that picks the cells which may invert. Every tested cell that holds FALSE pulls the shared line into its active state. A step strobe then inverts all flip-selected cells in one cycle, but only if the line is still at rest. One step therefore acts as a toggle with many controls: the flip happens only when every tested cell is TRUE.

The sequencer uses the block as a scratchpad for bit-serial arithmetic and tests. It can load the whole row in parallel, issue test/flip steps, and read the state vector and the live line status. The line is evaluated from the state before the step. A cell that is both tested and flipped therefore uses its old value. A parallel load in the same cycle as a step takes precedence over the step.

Top module: `ctrl_toggle_array`

## Requirements
- R1: After reset, every state bit is 0 and, with the test mask at zero, `cond_busy` is 0.
- R2: When `load_en` is 1 at a rising clock edge, `state` equals `load_word` after that edge.
- R3: When `load_en` and `step` are both 1 in one cycle, `load_word` is loaded and the flip mask has no effect.
- R4: `cond_busy` is 1 in the same cycle, with no register in the path, exactly when some bit set in `test_mask` has a 0 in `state`.
- R5: When `step` is 1, `load_en` is 0 and `cond_busy` is 0, every bit set in `flip_mask` inverts after the edge, and every other bit keeps its value.
- R6: When `step` is 1, `load_en` is 0 and `cond_busy` is 1, `state` does not change at that edge.
- R7: With `test_mask` all zero, `cond_busy` is 0, so a step inverts every flip-selected bit without condition.
- R8: A bit set in both `test_mask` and `flip_mask` is tested on its value before the step. A 1 lets the step invert it to 0. A 0 blocks the step.
- R9: With `load_en` and `step` both 0, `state` holds its value whatever the masks are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Parallel load strobe; takes precedence over `step` |
| load_word | input | WIDTH | Value written to the row on load |
| test_mask | input | WIDTH | Cells whose state gates the step (1 = tested) |
| flip_mask | input | WIDTH | Cells that invert on an unblocked step (1 = selected) |
| step | input | 1 | Performs one test-and-flip operation |
| state | output | WIDTH | Current contents of the row |
| cond_busy | output | 1 | Shared line status: 1 = active (some tested cell is FALSE) |

## Verification
`cond_busy` is combinational. The bench checks it one time unit after it drives the inputs on the falling edge, in the same cycle. Every change to `state` passes through one register, so its result is due at the next rising edge. For each operation the driver pushes the expected row into a queue. The monitor pops one entry shortly after each rising edge and compares it with `state`. Both sides therefore stay in step, one cycle apart, and no result is read before its register has updated.

// File: rtl/ctrl_toggle_pkg.sv
// Package: shared types for the controlled toggle array.
// Assumes: one operation is chosen for the whole row in each cycle.
package ctrl_toggle_pkg;

    // Operation applied to every cell in a cycle
    typedef enum logic [1:0] {
        ROW_HOLD = 2'd0,
        ROW_LOAD = 2'd1,
        ROW_FLIP = 2'd2
    } row_op_e;

endpackage

// File: rtl/ct_cond_line.sv
// Module: shared condition line of the array.
// Combines the per-cell pull requests into one active-high busy flag, as a
// wired line would do. Assumes each pull is 1 only when that cell is tested
// and holds FALSE.
module ct_cond_line #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] pull,
    output logic             busy
);

    // OR-reduce every cell's pull onto the one line
    always_comb begin
        busy = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            busy = busy | pull[i];
        end
    end

endmodule

// File: rtl/ct_op_decode.sv
// Module: picks the row operation for the current cycle.
// Load has priority over a step. A step becomes a flip only while the
// condition line is at rest. Assumes busy comes from pre-step state.
module ct_op_decode
    import ctrl_toggle_pkg::*;
(
    input  logic    load_en,
    input  logic    step,
    input  logic    busy,
    output row_op_e op
);

    // Priority decode: load, then unblocked step, else hold
    always_comb begin
        if (load_en) begin
            op = ROW_LOAD;
        end else if (step && !busy) begin
            op = ROW_FLIP;
        end else begin
            op = ROW_HOLD;
        end
    end

endmodule

// File: rtl/ct_cell.sv
// Module: one toggle cell.
// Stores one bit. Requests the condition line when tested and FALSE.
// Inverts on a row flip when selected. Assumes a synchronous active-low reset.
module ct_cell
    import ctrl_toggle_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  row_op_e op,
    input  logic    load_bit,
    input  logic    tested,
    input  logic    selected,
    output logic    q,
    output logic    pull
);

    logic q_next;

    // Pull the line when this tested cell holds FALSE
    always_comb begin
        pull = tested & ~q;
    end

    // Next-state choice for this cell
    always_comb begin
        unique case (op)
            ROW_LOAD: q_next = load_bit;
            ROW_FLIP: q_next = q ^ selected;
            default:  q_next = q;
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/ctrl_toggle_array.sv
// Module: controlled toggle register array (top).
// A row of WIDTH toggle cells shares one condition line. A step inverts the
// flip-selected cells only when every tested cell is TRUE. Assumes the masks
// and strobes are synchronous to clk. Load wins over step.
module ctrl_toggle_array
    import ctrl_toggle_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_word,
    input  logic [WIDTH-1:0] test_mask,
    input  logic [WIDTH-1:0] flip_mask,
    input  logic             step,
    output logic [WIDTH-1:0] state,
    output logic             cond_busy
);

    logic [WIDTH-1:0] pull_vec;
    logic [WIDTH-1:0] q_vec;
    row_op_e          row_op;

    ct_cond_line #(.WIDTH(WIDTH)) u_line (
        .pull (pull_vec),
        .busy (cond_busy)
    );

    ct_op_decode u_decode (
        .load_en (load_en),
        .step    (step),
        .busy    (cond_busy),
        .op      (row_op)
    );

    // One cell per bit of the row
    for (genvar g = 0; g < WIDTH; g++) begin : g_cell
        ct_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .op       (row_op),
            .load_bit (load_word[g]),
            .tested   (test_mask[g]),
            .selected (flip_mask[g]),
            .q        (q_vec[g]),
            .pull     (pull_vec[g])
        );
    end

    // Present the row state
    always_comb begin
        state = q_vec;
    end

endmodule

// File: rtl/ct_array_checker.sv
// Module: assertion checker for ctrl_toggle_array, attached by bind.
// Assumes a synchronous active-low reset. All checks are off while it is low.
module ct_array_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_en,
    input logic [WIDTH-1:0] load_word,
    input logic [WIDTH-1:0] test_mask,
    input logic [WIDTH-1:0] flip_mask,
    input logic             step,
    input logic [WIDTH-1:0] state,
    input logic             cond_busy
);

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> state == $past(load_word));

    assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && step) |=> state == $past(load_word));

    assert_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && step && !cond_busy) |=> state == ($past(state) ^ $past(flip_mask)));

    assert_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && step && cond_busy) |=> $stable(state));

    assert_no_test_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mask == '0) |-> !cond_busy);

    assert_all_true_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((test_mask & state) == test_mask) |-> !cond_busy);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !step) |=> $stable(state));

endmodule

bind ctrl_toggle_array ct_array_checker #(.WIDTH(WIDTH)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_word (load_word),
    .test_mask (test_mask),
    .flip_mask (flip_mask),
    .step      (step),
    .state     (state),
    .cond_busy (cond_busy)
);

// File: tb/test_ctrl_toggle_array.sv
// Bench: scoreboard test of ctrl_toggle_array. The driver pushes the
// expected row per operation. The monitor pops and compares after each edge.
module test_ctrl_toggle_array;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_en = 1'b0;
    logic [W-1:0] load_word = '0;
    logic [W-1:0] test_mask = '0;
    logic [W-1:0] flip_mask = '0;
    logic         step = 1'b0;
    logic [W-1:0] state;
    logic         cond_busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [W-1:0] model = '0;
    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    always #10 clk = ~clk;  // 50 MHz

    ctrl_toggle_array #(.WIDTH(W)) i_ctrl_toggle_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_word (load_word),
        .test_mask (test_mask),
        .flip_mask (flip_mask),
        .step      (step),
        .state     (state),
        .cond_busy (cond_busy)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: apply one operation, check the line now, queue the next row
    task automatic do_op(input string req, input logic ld, input logic [W-1:0] word,
                         input logic [W-1:0] tmask, input logic [W-1:0] fmask,
                         input logic stp);
        logic bus_exp;
        @(negedge clk);
        load_en = ld; load_word = word; test_mask = tmask; flip_mask = fmask; step = stp;
        bus_exp = |(tmask & ~model);
        #1;
        check({req, " R4 line"}, W'(cond_busy), W'(bus_exp));
        if (ld) model = word;
        else if (stp && !bus_exp) model = model ^ fmask;
        exp_q.push_back(model);
        tag_q.push_back(req);
    endtask

    // Monitor: compare the row after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                check(tag_q.pop_front(), state, exp_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 state", state, '0);
        check("R1 line", W'(cond_busy), '0);
        do_op("R2 load", 1'b1, 8'hA5, '0, '0, 1'b0);
        do_op("R9 hold", 1'b0, 8'h00, 8'hFF, 8'hFF, 1'b0);
        do_op("R5 flip", 1'b0, 8'h00, 8'h01, 8'hF0, 1'b1);        // A5 -> 55
        do_op("R6 blocked", 1'b0, 8'h00, 8'h02, 8'hFF, 1'b1);     // bit1 FALSE
        do_op("R7 no test", 1'b0, 8'h00, 8'h00, 8'h0F, 1'b1);     // 55 -> 5A
        do_op("R8 self true", 1'b0, 8'h00, 8'h02, 8'h02, 1'b1);   // 5A -> 58
        do_op("R8 self false", 1'b0, 8'h00, 8'h02, 8'h02, 1'b1);  // blocked
        do_op("R3 load wins", 1'b1, 8'h3C, 8'h00, 8'hFF, 1'b1);
        do_op("R5 multi test", 1'b0, 8'h00, 8'h3C, 8'hC3, 1'b1);  // 3C -> FF
        do_op("R2 reload", 1'b1, 8'hFE, 8'h00, 8'h00, 1'b0);
        do_op("R6 one false", 1'b0, 8'h00, 8'hFF, 8'hFF, 1'b1);
        do_op("R5 subset", 1'b0, 8'h00, 8'hFE, 8'h81, 1'b1);      // FE -> 7F
        do_op("R9 idle", 1'b0, 8'h00, 8'h00, 8'h00, 1'b0);
        @(negedge clk);
        load_en = 1'b0; step = 1'b0; test_mask = '0; flip_mask = '0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule